// File: doc/BRIEF.md
# Bit-Error-Rate Receive Checker

The block compares a serial bit stream, one bit per clock, with a pattern it rebuilds locally. The pattern is one of three maximal-length pseudorandom sequences or a short user word repeated over and over. First the checker hunts for alignment. It declares lock once it has seen a long enough run of correct predictions. While locked it counts every bit it receives and every bit that differs from the prediction. If errors arrive too densely it drops lock and starts hunting again without host action.

The host has three controls. An invert control complements every incoming bit before the comparison. A rising edge on the resync control throws away the current alignment and starts a new hunt. A rising edge on the latch control copies the live bit and error totals into two holding outputs and opens a new measurement window. The checker has no enable and runs on every clock. The pattern settings come in on plain input ports.

Top module: `bert_rx`

## Requirements
- R1: While reset is asserted, and on the first sample after it is released, sync_o is 0 and both bit_cnt_o and err_cnt_o are 0.
- R2: pat_sel_i selects the expected sequence b[n]. 0 gives b[n]=b[n-9]^b[n-5]. 1 gives b[n]=b[n-15]^b[n-14]. 2 gives b[n]=b[n-23]^b[n-18]. 3 repeats rep_pat_i bits 0 up to rep_len_i, least significant bit first, so the period is rep_len_i+1.
- R3: Outside lock, sync_o goes high in the cycle after the checker has taken LOCK_RUN (32) consecutive bits that matched its prediction. In the PRBS modes the incoming bits seed the local register during the hunt. In repeat mode each mismatch slips the local phase by one bit.
- R4: While locked, the checker drops sync_o in the cycle after the bit that makes ERR_LIMIT (6) errors within the last WIN_LEN (64) bits. Five errors in any 64 bits keep lock. After a drop, acquisition restarts automatically.
- R5: A rising edge of resync_i drops sync_o in the following cycle and restarts acquisition. The checker needs a fresh run of LOCK_RUN matches before it locks again.
- R6: When rx_inv_i is 1, each incoming bit is complemented before the comparison. A complemented stream then locks, and a true stream does not.
- R7: Only bits taken while sync_o is high are counted. Every such bit adds one to the bit total. Each one that differs from the prediction also adds one to the error total.
- R8: A rising edge of latch_i copies the live totals into bit_cnt_o and err_cnt_o in the next cycle. The bit taken on the edge cycle starts the new window, so a snapshot covers exactly the bits from the previous edge cycle up to the cycle before this one.
- R9: While latch_i stays high after an edge, bit_cnt_o and err_cnt_o do not change. latch_i must go low and rise again to take another snapshot.
- R10: The live totals are CNT_W bits wide (32 by default) and stop at all ones instead of wrapping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bit clock; one data bit per rising edge |
| rst_ni | input | 1 | Active-low asynchronous reset |
| data_i | input | 1 | Incoming serial bit |
| rx_inv_i | input | 1 | Complement incoming bits before comparison |
| pat_sel_i | input | 2 | Pattern select (encoding in R2) |
| rep_pat_i | input | 32 | Repeat-mode word, LSB sent first |
| rep_len_i | input | 5 | Repeat-mode period minus one |
| resync_i | input | 1 | Rising edge forces re-acquisition |
| latch_i | input | 1 | Rising edge snapshots totals and restarts them |
| sync_o | output | 1 | High while locked |
| bit_cnt_o | output | CNT_W | Bits counted in the last closed window |
| err_cnt_o | output | CNT_W | Errors counted in the last closed window |

## Verification
The bench drives the loss-of-lock limit on both sides. Six errors packed into 61 bits must drop lock exactly one cycle after the sixth error, and errors 13 bits apart must never drop it. A design that used fixed blocks instead of a sliding window, or that was off by one on the limit, would hold or lose lock on the wrong bit. The bench checks the 32-bit lock run by counting cycles from a resync edge, so a checker that locked early or late, or that ignored resync, fails that check. Snapshot windows are checked to the exact bit count. The bench also tests a held latch level, a stretch spent unlocked, and totals driven past a narrowed counter's maximum. Each of these catches a snapshot that is level-sensitive, a checker that counts during the hunt, and a counter that wraps.

// File: rtl/bert_rx_pkg.sv
package bert_rx_pkg;
  localparam int unsigned LFSR_W = 23;

  typedef enum logic [1:0] {
    PAT_P9  = 2'd0,
    PAT_P15 = 2'd1,
    PAT_P23 = 2'd2,
    PAT_REP = 2'd3
  } pat_sel_e;

  // s[0] holds the newest bit, s[k-1] the bit k places back
  function automatic logic prbs_fb(pat_sel_e sel, logic [LFSR_W-1:0] s);
    logic fb;
    case (sel)
      PAT_P9:  fb = s[8] ^ s[4];
      PAT_P15: fb = s[14] ^ s[13];
      default: fb = s[22] ^ s[17];
    endcase
    return fb;
  endfunction
endpackage

// File: rtl/bert_rx_rise.sv
module bert_rx_rise (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic lvl_i,
  output logic rise_o
);
  logic lvl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) lvl_q <= 1'b0;
    else         lvl_q <= lvl_i;
  end

  assign rise_o = lvl_i & ~lvl_q;
endmodule

// File: rtl/bert_rx_ref.sv
module bert_rx_ref
  import bert_rx_pkg::*;
#(
  parameter int unsigned REP_W = 32,
  localparam int unsigned PTR_W = $clog2(REP_W)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  pat_sel_e         sel_i,
  input  logic [REP_W-1:0] rep_pat_i,
  input  logic [PTR_W-1:0] rep_len_i,
  input  logic             in_bit_i,
  input  logic             hunt_i,
  output logic             exp_bit_o
);
  logic [LFSR_W-1:0] lfsr_q;
  logic [PTR_W-1:0]  ptr_q;
  logic              prbs_bit, rep_bit, slip;

  assign prbs_bit  = prbs_fb(sel_i, lfsr_q);
  assign rep_bit   = rep_pat_i[ptr_q];
  assign exp_bit_o = (sel_i == PAT_REP) ? rep_bit : prbs_bit;
  // hunting in repeat mode: hold phase on mismatch, i.e. slip one bit
  assign slip      = hunt_i && (sel_i == PAT_REP) && (in_bit_i != rep_bit);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lfsr_q <= '0;
      ptr_q  <= '0;
    end else begin
      lfsr_q <= {lfsr_q[LFSR_W-2:0], hunt_i ? in_bit_i : prbs_bit};
      if (!slip) ptr_q <= (ptr_q >= rep_len_i) ? '0 : ptr_q + PTR_W'(1);
    end
  end
endmodule

// File: rtl/bert_rx_lock.sv
module bert_rx_lock #(
  parameter int unsigned LOCK_RUN  = 32,
  parameter int unsigned WIN_LEN   = 64,
  parameter int unsigned ERR_LIMIT = 6,
  localparam int unsigned RUN_W  = $clog2(LOCK_RUN + 1),
  localparam int unsigned WCNT_W = $clog2(WIN_LEN + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic resync_i,
  input  logic match_i,
  output logic sync_o
);
  logic               locked_q;
  logic [RUN_W-1:0]   run_q;
  logic [WIN_LEN-1:0] hist_q;
  logic [WCNT_W-1:0]  wcnt_q, wcnt_nxt;
  logic               err, drop, lose;

  assign err      = ~match_i;
  assign drop     = hist_q[WIN_LEN-1];
  assign wcnt_nxt = wcnt_q + {{(WCNT_W-1){1'b0}}, err} - {{(WCNT_W-1){1'b0}}, drop};
  assign lose     = wcnt_nxt >= WCNT_W'(ERR_LIMIT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      locked_q <= 1'b0;
      run_q    <= '0;
      hist_q   <= '0;
      wcnt_q   <= '0;
    end else if (resync_i) begin
      locked_q <= 1'b0;
      run_q    <= '0;
      hist_q   <= '0;
      wcnt_q   <= '0;
    end else if (!locked_q) begin
      hist_q <= '0;
      wcnt_q <= '0;
      if (!match_i) begin
        run_q <= '0;
      end else if (run_q == RUN_W'(LOCK_RUN - 1)) begin
        run_q    <= '0;
        locked_q <= 1'b1;
      end else begin
        run_q <= run_q + RUN_W'(1);
      end
    end else if (lose) begin
      locked_q <= 1'b0;
      hist_q   <= '0;
      wcnt_q   <= '0;
    end else begin
      hist_q <= {hist_q[WIN_LEN-2:0], err};
      wcnt_q <= wcnt_nxt;
    end
  end

  assign sync_o = locked_q;
endmodule

// File: rtl/bert_rx_tally.sv
module bert_rx_tally #(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             bit_en_i,
  input  logic             err_en_i,
  input  logic             snap_i,
  output logic [CNT_W-1:0] bit_cnt_o,
  output logic [CNT_W-1:0] err_cnt_o
);
  localparam int unsigned LANES = 2;

  logic [LANES-1:0]       inc;
  logic [CNT_W-1:0]       held [LANES];

  assign inc = {err_en_i, bit_en_i};

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    logic [CNT_W-1:0] live_q, held_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        live_q <= '0;
        held_q <= '0;
      end else if (snap_i) begin
        held_q <= live_q;
        live_q <= {{(CNT_W-1){1'b0}}, inc[k]};  // edge-cycle bit opens new window
      end else if (inc[k] && (live_q != '1)) begin
        live_q <= live_q + CNT_W'(1);
      end
    end

    assign held[k] = held_q;
  end

  assign bit_cnt_o = held[0];
  assign err_cnt_o = held[1];
endmodule

// File: rtl/bert_rx.sv
module bert_rx
  import bert_rx_pkg::*;
#(
  parameter int unsigned CNT_W     = 32,
  parameter int unsigned LOCK_RUN  = 32,
  parameter int unsigned WIN_LEN   = 64,
  parameter int unsigned ERR_LIMIT = 6,
  parameter int unsigned REP_W     = 32,
  localparam int unsigned PTR_W    = $clog2(REP_W)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             data_i,
  input  logic             rx_inv_i,
  input  logic [1:0]       pat_sel_i,
  input  logic [REP_W-1:0] rep_pat_i,
  input  logic [PTR_W-1:0] rep_len_i,
  input  logic             resync_i,
  input  logic             latch_i,
  output logic             sync_o,
  output logic [CNT_W-1:0] bit_cnt_o,
  output logic [CNT_W-1:0] err_cnt_o
);
  logic     in_bit, exp_bit, match, locked;
  logic     resync_rise, latch_rise;
  pat_sel_e sel;

  assign sel    = pat_sel_e'(pat_sel_i);
  assign in_bit = data_i ^ rx_inv_i;
  assign match  = (in_bit == exp_bit);

  bert_rx_rise u_resync_edge (
    .clk_i (clk_i), .rst_ni (rst_ni), .lvl_i (resync_i), .rise_o (resync_rise)
  );

  bert_rx_rise u_latch_edge (
    .clk_i (clk_i), .rst_ni (rst_ni), .lvl_i (latch_i), .rise_o (latch_rise)
  );

  bert_rx_ref #(.REP_W(REP_W)) u_ref (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .sel_i     (sel),
    .rep_pat_i (rep_pat_i),
    .rep_len_i (rep_len_i),
    .in_bit_i  (in_bit),
    .hunt_i    (~locked),
    .exp_bit_o (exp_bit)
  );

  bert_rx_lock #(
    .LOCK_RUN (LOCK_RUN),
    .WIN_LEN  (WIN_LEN),
    .ERR_LIMIT(ERR_LIMIT)
  ) u_lock (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .resync_i (resync_rise),
    .match_i  (match),
    .sync_o   (locked)
  );

  bert_rx_tally #(.CNT_W(CNT_W)) u_tally (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .bit_en_i  (locked),
    .err_en_i  (locked & ~match),
    .snap_i    (latch_rise),
    .bit_cnt_o (bit_cnt_o),
    .err_cnt_o (err_cnt_o)
  );

  assign sync_o = locked;
endmodule

// File: rtl/bert_rx_chk.sv
module bert_rx_chk #(
  parameter int unsigned CNT_W    = 32,
  parameter int unsigned LOCK_RUN = 32,
  localparam int unsigned RUN_W   = $clog2(LOCK_RUN + 1)
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             resync_i,
  input logic             latch_i,
  input logic             sync_o,
  input logic [CNT_W-1:0] bit_cnt_o,
  input logic [CNT_W-1:0] err_cnt_o
);
  logic [RUN_W-1:0] low_cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                          low_cnt_q <= '0;
    else if (sync_o)                      low_cnt_q <= '0;
    else if (low_cnt_q != RUN_W'(LOCK_RUN)) low_cnt_q <= low_cnt_q + RUN_W'(1);
  end

  // R3
  lock_run_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sync_o) |-> (low_cnt_q >= RUN_W'(LOCK_RUN)));

  // R5
  resync_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(resync_i) |=> !sync_o);

  // R9
  snap_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$rose(latch_i) |=> ($stable(bit_cnt_o) && $stable(err_cnt_o)));

  // R7
  err_le_bits_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_cnt_o <= bit_cnt_o);
endmodule

bind bert_rx bert_rx_chk #(.CNT_W(CNT_W), .LOCK_RUN(LOCK_RUN)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .resync_i  (resync_i),
  .latch_i   (latch_i),
  .sync_o    (sync_o),
  .bit_cnt_o (bit_cnt_o),
  .err_cnt_o (err_cnt_o)
);

// File: tb/bert_rx_test.sv
`timescale 1ns/1ps
module bert_rx_test;
  localparam int CW = 12;
  localparam int NV = 6;

  typedef struct packed {
    logic [1:0]  sel;
    logic        rinv;
    logic        dinv;
    logic [4:0]  len;
    logic [31:0] pat;
    logic [15:0] nbits;
    logic [7:0]  per;
    logic [15:0] nerr;
    logic        lock;
    logic        cnt;
  } vec_t;

  // sel rinv dinv len pat nbits per nerr lock cnt
  localparam vec_t VEC [NV] = '{
    '{2'd0, 1'b0, 1'b0, 5'd0,  32'h0,         16'd300, 8'd0,  16'd0,  1'b1, 1'b1},
    '{2'd1, 1'b1, 1'b1, 5'd0,  32'h0,         16'd300, 8'd0,  16'd0,  1'b1, 1'b1},
    '{2'd2, 1'b0, 1'b0, 5'd0,  32'h0,         16'd400, 8'd20, 16'd20, 1'b1, 1'b1},
    '{2'd3, 1'b0, 1'b0, 5'd23, 32'hA5C3_0F17, 16'd250, 8'd40, 16'd6,  1'b1, 1'b1},
    '{2'd0, 1'b0, 1'b0, 5'd0,  32'h0,         16'd300, 8'd10, 16'd0,  1'b0, 1'b0},
    '{2'd1, 1'b1, 1'b0, 5'd0,  32'h0,         16'd300, 8'd0,  16'd0,  1'b0, 1'b0}
  };

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic          data_i = 1'b0, rx_inv_i = 1'b0, resync_i = 1'b0, latch_i = 1'b0;
  logic [1:0]    pat_sel_i = 2'd0;
  logic [31:0]   rep_pat_i = '0;
  logic [4:0]    rep_len_i = '0;
  logic          sync_o;
  logic [CW-1:0] bit_cnt_o, err_cnt_o;

  logic          drv_inv = 1'b0;
  logic [22:0]   g = 23'h1;
  int            gi = 0;
  int            total = 0, bad = 0;
  bit            done = 1'b0;

  always #2.5 clk = ~clk;

  bert_rx #(.CNT_W(CW)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .data_i(data_i), .rx_inv_i(rx_inv_i),
    .pat_sel_i(pat_sel_i), .rep_pat_i(rep_pat_i), .rep_len_i(rep_len_i),
    .resync_i(resync_i), .latch_i(latch_i), .sync_o(sync_o),
    .bit_cnt_o(bit_cnt_o), .err_cnt_o(err_cnt_o)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // one bit per call: drive after a falling edge, return on the next one
  task automatic bit_step(input bit flip);
    logic b;
    if (pat_sel_i == 2'd3) begin
      b = rep_pat_i[gi];
      gi = (gi >= int'(rep_len_i)) ? 0 : gi + 1;
    end else begin
      case (pat_sel_i)
        2'd0:    b = g[8] ^ g[4];
        2'd1:    b = g[14] ^ g[13];
        default: b = g[22] ^ g[17];
      endcase
      g = {g[21:0], b};
    end
    data_i = b ^ drv_inv ^ flip;
    @(negedge clk);
  endtask

  task automatic clean(input int n);
    for (int i = 0; i < n; i++) bit_step(1'b0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    vec_t cv;
    logic [31:0] held_b;
    repeat (3) @(negedge clk);
    chk("R1 sync in reset", 32'(sync_o), 0);
    rst_ni = 1'b1;
    @(negedge clk);
    chk("R1 sync after reset", 32'(sync_o), 0);
    chk("R1 bit snapshot after reset", 32'(bit_cnt_o), 0);
    chk("R1 err snapshot after reset", 32'(err_cnt_o), 0);

    // table walk: R2 patterns, R6 inversion, R7/R8 window counts
    for (int v = 0; v < NV; v++) begin
      cv = VEC[v];
      pat_sel_i = cv.sel; rx_inv_i = cv.rinv; drv_inv = cv.dinv;
      rep_len_i = cv.len; rep_pat_i = cv.pat; gi = 0;
      resync_i = 1'b1; bit_step(1'b0); resync_i = 1'b0;
      clean(1000);
      if (cv.lock) chk($sformatf("R2 R3 lock vec%0d", v), 32'(sync_o), 1);
      latch_i = 1'b1;
      for (int i = 0; i < int'(cv.nbits); i++) begin
        bit_step((cv.per != 0) && (i % int'(cv.per) == int'(cv.per) - 1));
        latch_i = 1'b0;
      end
      latch_i = 1'b1; bit_step(1'b0); latch_i = 1'b0;
      chk($sformatf("R4 R6 sync at end vec%0d", v), 32'(sync_o), 32'(cv.lock));
      if (cv.cnt) begin
        chk($sformatf("R8 bit window vec%0d", v), 32'(bit_cnt_o), 32'(cv.nbits));
        chk($sformatf("R7 error total vec%0d", v), 32'(err_cnt_o), 32'(cv.nerr));
      end
    end

    // R5 and R3: exact lock run after resync
    pat_sel_i = 2'd0; rx_inv_i = 1'b0; drv_inv = 1'b0;
    resync_i = 1'b1; bit_step(1'b0); resync_i = 1'b0;
    clean(100);
    chk("R3 locked before resync", 32'(sync_o), 1);
    resync_i = 1'b1; bit_step(1'b0); resync_i = 1'b0;
    chk("R5 sync drops after resync edge", 32'(sync_o), 0);
    clean(31);
    chk("R3 still hunting after 31 matches", 32'(sync_o), 0);
    clean(1);
    chk("R3 locked after 32 matches", 32'(sync_o), 1);

    // R4: five errors per 64 bits keep lock
    for (int i = 0; i < 70; i++) bit_step(i % 13 == 0);
    chk("R4 five per window keeps lock", 32'(sync_o), 1);
    clean(100);
    for (int i = 0; i < 60; i++) bit_step(i % 12 == 0);
    chk("R4 lock held before sixth error", 32'(sync_o), 1);
    bit_step(1'b1);
    chk("R4 lock lost on sixth error", 32'(sync_o), 0);
    clean(100);
    chk("R4 automatic reacquire", 32'(sync_o), 1);

    // R9 held latch level, then R8 window length
    latch_i = 1'b1; bit_step(1'b0);
    held_b = 32'(bit_cnt_o);
    clean(50);
    chk("R9 snapshot held while latch high", 32'(bit_cnt_o), held_b);
    latch_i = 1'b0; bit_step(1'b0);
    latch_i = 1'b1; bit_step(1'b0);
    chk("R8 window after rearm", 32'(bit_cnt_o), 52);

    // R7: hunting bits are not counted
    latch_i = 1'b0; bit_step(1'b0);
    latch_i = 1'b1; bit_step(1'b0); latch_i = 1'b0;
    clean(4);
    resync_i = 1'b1; bit_step(1'b0); resync_i = 1'b0;
    clean(44);
    latch_i = 1'b1; bit_step(1'b0);
    chk("R7 unlocked bits skipped", 32'(bit_cnt_o), 18);
    chk("R7 no errors on clean data", 32'(err_cnt_o), 0);

    // R10 saturation on a narrowed counter
    latch_i = 1'b0; bit_step(1'b0);
    latch_i = 1'b1; bit_step(1'b0); latch_i = 1'b0;
    for (int i = 0; i < 55000; i++) bit_step(i % 13 == 0);
    latch_i = 1'b1; bit_step(1'b0); latch_i = 1'b0;
    chk("R10 bit total saturates", 32'(bit_cnt_o), 32'((1 << CW) - 1));
    chk("R10 error total saturates", 32'(err_cnt_o), 32'((1 << CW) - 1));
    chk("R4 lock kept through sparse errors", 32'(sync_o), 1);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule